// File: doc/BRIEF.md
# Dual-Latency Trigger Hit Pipeline

This block keeps the zero-suppressed hits of every bunch crossing in a circular store, one crossing per clock at 80 MHz. Two trigger inputs with different fixed latencies each ask for one past crossing. An early pre-trigger, 256 crossings (3.2 µs) after the crossing, sends that crossing's hits out toward the track trigger. A later level-1 accept, 512 crossings (6.4 µs) after the crossing, sends the same crossing's hits out again toward data acquisition. A third read tap at 80 crossings (1.0 µs) shows one crossing per cycle to the local doublet correlation logic.

A crossing holds a hit count and up to four 16-bit hits. A requested crossing is read into a snapshot on the cycle its trigger is sampled, so a readout still completes after the slot has been overwritten. The snapshots wait in a short queue and leave on one 16-bit output as a header word followed by the hit words. When both triggers arrive together, the level-1 snapshot enters the queue ahead of the pre-trigger snapshot. A request that finds no room in the queue is dropped and raises a sticky error flag.

Top module: `dual_latency_hit_pipe`

## Requirements
- R1: On every clock out of reset one crossing is stored at the slot given by a 9-bit crossing counter that starts at 0 after reset and wraps modulo 512; an input count above 4 is stored as 4.
- R2: After the rising edge that stores crossing n, the tap outputs show crossing n-80: `tapBx` = (n-80) mod 512, its stored count and all four stored hit fields; `tapValid` is 1 only once n is at least 80.
- R3: A pre-trigger sampled on the edge that stores crossing n, with n at least 256, reads out crossing n-256. With the queue empty and no readout in progress, its header word is presented after the second rising edge that follows the sampling edge.
- R4: A level-1 accept sampled on the edge that stores crossing n, with n at least 512, reads out crossing n-512, meaning the contents the slot held before that same edge overwrote it.
- R5: A readout is one header word with `outHeader`=1, then one word per stored hit in slot order 0 to count-1 (hit i is input bits 16i+15 down to 16i), one word per cycle with `outValid`=1. Header layout: bit 15 = 1 for level-1 and 0 for pre-trigger, bits 14:12 = count, bits 11:9 = 0, bits 8:0 = crossing number. A crossing with count 0 gives a header only.
- R6: Readouts leave in the order their requests were taken; when both triggers are sampled on the same edge, the level-1 readout comes first.
- R7: Up to 4 requests wait in the queue. A request that finds the queue full is dropped and sets `ovfErr`, which stays 1 until reset.
- R8: A pre-trigger before crossing 256 and a level-1 accept before crossing 512 (counted since reset) are ignored and produce no output words.
- R9: During and right after reset, `outValid`, `outHeader`, `ovfErr` and `tapValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock, one crossing per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inCount | input | 3 | Number of hits in the current crossing |
| inHits | input | 64 | Four 16-bit hit fields of the current crossing, hit 0 in the low bits |
| trigPt | input | 1 | Pre-trigger for the crossing 256 before the current one |
| trigL1 | input | 1 | Level-1 accept for the crossing 512 before the current one |
| outValid | output | 1 | Readout word valid |
| outHeader | output | 1 | Current readout word is a header |
| outWord | output | 16 | Readout word |
| ovfErr | output | 1 | Sticky flag: a request was dropped |
| tapValid | output | 1 | Tap outputs carry a stored crossing |
| tapBx | output | 9 | Crossing number on the tap |
| tapCount | output | 3 | Hit count on the tap |
| tapHits | output | 64 | Four hit fields on the tap |

## Verification
The properties take for granted that every crossing read after the fill period was written since reset. Only the overflow property expects the queue to be able to fill, and it needs the triggers to arrive faster than the output drains. The random phase therefore keeps at least twelve idle crossings between trigger events, each of which is a pre-trigger, a level-1 accept or both. That spacing outlasts the longest pair of readouts, so the exact output stream can be predicted. A separate directed burst fires both triggers on six crossings in a row to force drops and checks only the error flag and the number of headers that come out. Counts from 0 to 7 are driven to exercise the clamp, and early triggers are driven inside the fill window.

// File: rtl/dlhp_pkg.sv
package dlhp_pkg;
  localparam int HIT_W      = 16;
  localparam int MAX_HITS   = 4;
  localparam int CNT_W      = $clog2(MAX_HITS + 1);
  localparam int HIDX_W     = $clog2(MAX_HITS);
  localparam int BX_W       = 9;
  localparam int DEPTH      = 1 << BX_W;
  localparam int LAT_TAP    = 80;
  localparam int LAT_PT     = 256;
  localparam int LAT_L1     = 512;
  localparam int FIFO_DEPTH = 4;
  localparam int FP_W       = $clog2(FIFO_DEPTH);
  localparam int OCC_W      = $clog2(FIFO_DEPTH + 1);
  localparam int FILL_W     = $clog2(DEPTH + 1);
  localparam int HDR_PAD    = HIT_W - 1 - CNT_W - BX_W;

  typedef logic [MAX_HITS-1:0][HIT_W-1:0] hitvec_t;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    hitvec_t          hits;
  } slot_t;

  typedef struct packed {
    logic            isL1;
    logic [BX_W-1:0] bx;
    slot_t           slot;
  } req_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [BX_W-1:0]   wrAddr;
    logic [BX_W-1:0]   tapAddr;
    logic [BX_W-1:0]   ptAddr;
    logic [BX_W-1:0]   l1Addr;
    logic              pushFirst;
    logic              firstIsL1;
    logic [FP_W-1:0]   firstSlot;
    logic              pushSecond;
    logic [FP_W-1:0]   secondSlot;
    logic              load;
    logic [FP_W-1:0]   headSlot;
    logic              emitHit;
    logic [HIDX_W-1:0] hitIdx;
  } strobe_t;
endpackage

// File: rtl/dlhp_ctrl.sv
module dlhp_ctrl
  import dlhp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             trigPt,
  input  logic             trigL1,
  input  logic [CNT_W-1:0] headCnt,
  output strobe_t          sb,
  output logic             ovfErr,
  output logic             tapValid
);
  logic [BX_W-1:0]   bxNow;
  logic [FILL_W-1:0] fill;
  logic              ptV, l1V;
  logic [FP_W-1:0]   wrPtr, rdPtr;
  logic [OCC_W-1:0]  occ;
  logic [CNT_W-1:0]  rem;
  logic [HIDX_W-1:0] idx;

  logic              ptOk, l1Ok, anyReq, bothReq, pop, dropNow;
  logic [OCC_W-1:0]  freeSlots, nPush;

  always_comb begin
    // a trigger counts only once its target crossing has been stored since reset
    ptOk      = trigPt && (fill >= FILL_W'(LAT_PT));
    l1Ok      = trigL1 && (fill >= FILL_W'(LAT_L1));
    anyReq    = ptV || l1V;
    bothReq   = ptV && l1V;
    freeSlots = OCC_W'(FIFO_DEPTH) - occ;

    sb            = '0;
    sb.wrAddr     = bxNow;
    sb.tapAddr    = bxNow - BX_W'(LAT_TAP);
    sb.ptAddr     = bxNow - BX_W'(LAT_PT);
    sb.l1Addr     = bxNow - BX_W'(LAT_L1);
    // the level-1 snapshot takes the first free slot when both are pending
    sb.pushFirst  = anyReq && (freeSlots != '0);
    sb.firstIsL1  = l1V;
    sb.firstSlot  = wrPtr;
    sb.pushSecond = bothReq && (freeSlots >= OCC_W'(2));
    sb.secondSlot = wrPtr + FP_W'(1);
    sb.emitHit    = (rem != '0);
    sb.hitIdx     = idx;
    sb.load       = (rem == '0) && (occ != '0);
    sb.headSlot   = rdPtr;

    nPush   = OCC_W'(sb.pushFirst) + OCC_W'(sb.pushSecond);
    pop     = sb.load;
    dropNow = (anyReq && !sb.pushFirst) || (bothReq && !sb.pushSecond);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bxNow    <= '0;
      fill     <= '0;
      ptV      <= 1'b0;
      l1V      <= 1'b0;
      wrPtr    <= '0;
      rdPtr    <= '0;
      occ      <= '0;
      rem      <= '0;
      idx      <= '0;
      ovfErr   <= 1'b0;
      tapValid <= 1'b0;
    end else begin
      bxNow    <= bxNow + BX_W'(1);
      if (fill != FILL_W'(DEPTH)) fill <= fill + FILL_W'(1);
      tapValid <= (fill >= FILL_W'(LAT_TAP));
      ptV      <= ptOk;
      l1V      <= l1Ok;
      wrPtr    <= wrPtr + FP_W'(nPush);
      if (pop) rdPtr <= rdPtr + FP_W'(1);
      occ      <= occ + nPush - OCC_W'(pop);
      if (dropNow) ovfErr <= 1'b1;
      if (sb.load) begin
        rem <= headCnt;
        idx <= '0;
      end else if (sb.emitHit) begin
        rem <= rem - CNT_W'(1);
        idx <= idx + HIDX_W'(1);
      end
    end
  end

  p_occ_bound_r7: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(FIFO_DEPTH));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ovfErr |=> ovfErr);

  p_quiet_early_r8: assert property (@(posedge clk) disable iff (rst)
    (fill < FILL_W'(LAT_PT)) |-> (occ == '0 && rem == '0));

  p_rem_bound_r5: assert property (@(posedge clk) disable iff (rst)
    rem <= CNT_W'(MAX_HITS));
endmodule

// File: rtl/dlhp_datapath.sv
module dlhp_datapath
  import dlhp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          sb,
  input  logic [CNT_W-1:0] inCount,
  input  hitvec_t          inHits,
  output logic [CNT_W-1:0] headCnt,
  output logic             outValid,
  output logic             outHeader,
  output logic [HIT_W-1:0] outWord,
  output logic [BX_W-1:0]  tapBx,
  output slot_t            tapSlot
);
  slot_t            mem [DEPTH];
  slot_t            ptData, l1Data;
  logic [BX_W-1:0]  ptBx, l1Bx;
  req_t             fifo [FIFO_DEPTH];
  req_t             firstReq, secondReq, headReq;
  hitvec_t          curHits;
  logic [CNT_W-1:0] cntClamped;

  always_comb begin
    cntClamped = (inCount > CNT_W'(MAX_HITS)) ? CNT_W'(MAX_HITS) : inCount;
    firstReq   = sb.firstIsL1 ? {1'b1, l1Bx, l1Data} : {1'b0, ptBx, ptData};
    secondReq  = {1'b0, ptBx, ptData};
    headReq    = fifo[sb.headSlot];
    headCnt    = headReq.slot.cnt;
  end

  // store plus three read ports; a read of the slot written on the same edge
  // returns its previous contents, which the longest latency relies on
  always_ff @(posedge clk) begin
    mem[sb.wrAddr] <= {cntClamped, inHits};
    ptData  <= mem[sb.ptAddr];
    l1Data  <= mem[sb.l1Addr];
    tapSlot <= mem[sb.tapAddr];
    ptBx    <= sb.ptAddr;
    l1Bx    <= sb.l1Addr;
    tapBx   <= sb.tapAddr;
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < FIFO_DEPTH; s++) begin
      if (sb.pushFirst && sb.firstSlot == FP_W'(s))
        fifo[s] <= firstReq;
      else if (sb.pushSecond && sb.secondSlot == FP_W'(s))
        fifo[s] <= secondReq;
    end
    if (sb.load) curHits <= headReq.slot.hits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      outHeader <= 1'b0;
      outWord   <= '0;
    end else begin
      outValid  <= sb.load || sb.emitHit;
      outHeader <= sb.load;
      if (sb.load)
        outWord <= {headReq.isL1, headReq.slot.cnt, {HDR_PAD{1'b0}}, headReq.bx};
      else if (sb.emitHit)
        outWord <= curHits[sb.hitIdx];
    end
  end

  p_hit_after_word_r5: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outHeader) |-> $past(outValid));
endmodule

// File: rtl/dual_latency_hit_pipe.sv
module dual_latency_hit_pipe
  import dlhp_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [CNT_W-1:0]          inCount,
  input  logic [MAX_HITS*HIT_W-1:0] inHits,
  input  logic                      trigPt,
  input  logic                      trigL1,
  output logic                      outValid,
  output logic                      outHeader,
  output logic [HIT_W-1:0]          outWord,
  output logic                      ovfErr,
  output logic                      tapValid,
  output logic [BX_W-1:0]           tapBx,
  output logic [CNT_W-1:0]          tapCount,
  output logic [MAX_HITS*HIT_W-1:0] tapHits
);
  strobe_t          sb;
  logic [CNT_W-1:0] headCnt;
  hitvec_t          hitsIn;
  slot_t            tapSlot;

  assign hitsIn   = inHits;
  assign tapCount = tapSlot.cnt;
  assign tapHits  = tapSlot.hits;

  dlhp_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .trigPt   (trigPt),
    .trigL1   (trigL1),
    .headCnt  (headCnt),
    .sb       (sb),
    .ovfErr   (ovfErr),
    .tapValid (tapValid)
  );

  dlhp_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .sb        (sb),
    .inCount   (inCount),
    .inHits    (hitsIn),
    .headCnt   (headCnt),
    .outValid  (outValid),
    .outHeader (outHeader),
    .outWord   (outWord),
    .tapBx     (tapBx),
    .tapSlot   (tapSlot)
  );
endmodule

// File: tb/dual_latency_hit_pipe_bench.sv
module dual_latency_hit_pipe_bench;
  import dlhp_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                      rst;
  logic [CNT_W-1:0]          inCount;
  logic [MAX_HITS*HIT_W-1:0] inHits;
  logic                      trigPt, trigL1;
  logic                      outValid, outHeader, ovfErr, tapValid;
  logic [HIT_W-1:0]          outWord;
  logic [BX_W-1:0]           tapBx;
  logic [CNT_W-1:0]          tapCount;
  logic [MAX_HITS*HIT_W-1:0] tapHits;

  dual_latency_hit_pipe u_dual_latency_hit_pipe (
    .clk(clk), .rst(rst), .inCount(inCount), .inHits(inHits),
    .trigPt(trigPt), .trigL1(trigL1), .outValid(outValid),
    .outHeader(outHeader), .outWord(outWord), .ovfErr(ovfErr),
    .tapValid(tapValid), .tapBx(tapBx), .tapCount(tapCount), .tapHits(tapHits)
  );

  int vecs = 0, fails = 0;
  int nCross = 0, outSeen = 0, hdrSeen = 0;
  bit checkStream = 1'b1, done = 1'b0;
  logic [HIT_W:0] expQ [$];
  logic [HIT_W:0] monE;
  logic [CNT_W-1:0]          mCnt  [DEPTH];
  logic [MAX_HITS*HIT_W-1:0] mHits [DEPTH];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CNT_W-1:0] clampCnt(input int c);
    return (c > MAX_HITS) ? CNT_W'(MAX_HITS) : CNT_W'(c);
  endfunction

  function automatic logic [MAX_HITS*HIT_W-1:0] rndHits();
    return {$urandom, $urandom};
  endfunction

  // expected words for one readout of crossing c
  task automatic pushExp(input bit isL1, input int c);
    int ix = c % DEPTH;
    logic [CNT_W-1:0] k = mCnt[ix];
    expQ.push_back({1'b1, isL1, k, {HDR_PAD{1'b0}}, BX_W'(ix)});
    for (int i = 0; i < int'(k); i++)
      expQ.push_back({1'b0, mHits[ix][i*HIT_W +: HIT_W]});
  endtask

  // drive one crossing, wait for its edge, then check the tap
  task automatic step(input int cnt, input logic [MAX_HITS*HIT_W-1:0] hits, input bit pt, input bit l1);
    int n = nCross;
    if (checkStream) begin
      if (l1 && n >= LAT_L1) pushExp(1'b1, n - LAT_L1);   // R4, R6 level-1 first
      if (pt && n >= LAT_PT) pushExp(1'b0, n - LAT_PT);   // R3
    end
    mCnt[n % DEPTH]  = clampCnt(cnt);                      // R1 clamp
    mHits[n % DEPTH] = hits;
    inCount = CNT_W'(cnt);
    inHits  = hits;
    trigPt  = pt;
    trigL1  = l1;
    @(negedge clk);
    nCross++;
    if (n >= LAT_TAP) begin
      int t = (n - LAT_TAP) % DEPTH;
      chk(tapValid == 1'b1 && tapBx == BX_W'(t), "R2 tap crossing", {tapValid, tapBx}, {1'b1, BX_W'(t)});
      chk(tapCount == mCnt[t], "R1 R2 tap count", tapCount, mCnt[t]);
      chk(tapHits == mHits[t], "R2 tap hits", tapHits, mHits[t]);
    end else begin
      chk(tapValid == 1'b0, "R2 tap not yet valid", tapValid, 0);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && outValid) begin
      outSeen++;
      if (outHeader) hdrSeen++;
      if (checkStream) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R3 R4 R8 unexpected word", {outHeader, outWord}, 0);
        end else begin
          monE = expQ.pop_front();
          chk({outHeader, outWord} == monE, "R5 R6 stream word", {outHeader, outWord}, monE);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R3 act=running exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    int guard;
    bit pt, l1;
    void'($urandom(32'd4242));
    rst = 1'b1; inCount = '0; inHits = '0; trigPt = 1'b0; trigL1 = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(outValid == 1'b0 && outHeader == 1'b0, "R9 no output in reset", {outValid, outHeader}, 0);
    chk(ovfErr == 1'b0, "R9 error clear in reset", ovfErr, 0);
    chk(tapValid == 1'b0, "R9 tap invalid in reset", tapValid, 0);
    rst = 1'b0;

    // R8: triggers inside the fill window must give nothing
    for (int n = 0; n < 300; n++)
      step(int'($urandom % 8), rndHits(), n == 10 || n == 100 || n == 255,
           n == 10 || n == 200 || n == 260 || n == 299);
    chk(outSeen == 0, "R8 early triggers ignored", outSeen, 0);

    // R3 latency: header after the second edge past the trigger edge
    step(3, rndHits(), 1'b1, 1'b0);
    chk(outValid == 1'b0, "R3 no word one edge early", outValid, 0);
    step(0, rndHits(), 1'b0, 1'b0);
    chk(outValid == 1'b0, "R3 no word at next edge", outValid, 0);
    step(0, rndHits(), 1'b0, 1'b0);
    chk(outValid && outHeader && outWord[BX_W-1:0] == BX_W'(300 - LAT_PT),
        "R3 header on second edge", {outValid, outHeader, outWord}, {2'b11, 16'h0});
    repeat (10) step(0, '0, 1'b0, 1'b0);

    // constrained random, triggers spaced so the queue never backs up
    guard = 0;
    while (nCross < 3000) begin
      pt = 1'b0; l1 = 1'b0;
      if (guard > 0) guard--;
      else if ($urandom % 5 == 0) begin
        case ($urandom % 3)
          0: pt = 1'b1;
          1: l1 = 1'b1;
          default: begin pt = 1'b1; l1 = 1'b1; end
        endcase
        guard = 12;
      end
      step(int'($urandom % 8), rndHits(), pt, l1);
    end
    // directed R6: both at once, full crossings behind them
    step(4, rndHits(), 1'b1, 1'b1);
    repeat (20) step(0, '0, 1'b0, 1'b0);
    chk(expQ.size() == 0, "R3 R4 R6 all readouts seen", expQ.size(), 0);
    chk(ovfErr == 1'b0, "R7 no drop under spaced load", ovfErr, 0);

    // R7 overflow burst
    checkStream = 1'b0;
    expQ.delete();
    hdrSeen = 0;
    repeat (6) step(4, rndHits(), 1'b1, 1'b1);
    repeat (40) step(0, '0, 1'b0, 1'b0);
    chk(ovfErr == 1'b1, "R7 overflow sets flag", ovfErr, 1);
    chk(hdrSeen < 12 && hdrSeen >= FIFO_DEPTH, "R7 requests dropped", hdrSeen, FIFO_DEPTH);
    repeat (20) step(0, '0, 1'b0, 1'b0);
    chk(ovfErr == 1'b1, "R7 flag sticky", ovfErr, 1);

    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(ovfErr == 1'b0 && outValid == 1'b0, "R7 R9 reset clears", {ovfErr, outValid}, 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule